// File: doc/BRIEF.md
# Virtualization Field Access Outcome Sequencer

This block settles how a single field read or field write instruction against a virtual-machine control structure resolves. It looks at the processor mode flags, the current privilege level, whether the processor is running a guest, the validity of the current and the shadow (link) structure pointers, the upper half of the field selector, the verdicts of the field decoder (field supported, field read-only) and the exit request from the access-bitmap checker. From these it picks exactly one outcome: undefined-opcode fault, general-protection fault, VM exit, fail-invalid, fail-valid with an error code, or success.

A start strobe launches the decision. One cycle later the block raises a one-cycle done pulse with a one-hot result vector, the six arithmetic status flags to commit, a flag write enable, an error-field write strobe with its code, and an indication that a successful access is directed to the shadow structure. Field storage, address decoding and memory traffic stay with the neighbouring logic; the lower half of the selector is consumed by the field decoder and never reaches this block.

Top module: `vfa_outcome_seq`

## Requirements
- R1: When start is seen with virtualization off, or protected mode off, or the compatibility sub-mode active, the result is the undefined-opcode fault (result bit 0), with no flag write and no error write.
- R2: In guest mode, with R1 not applying, an exit request from the bitmap checker yields the VM exit result (bit 2), with no flag or error write.
- R3: In guest mode without an exit request, the pointer checked is the link pointer, not the current pointer, and a successful access raises use_shadow; outside guest mode use_shadow stays low.
- R4: Outside guest mode, with R1 not applying, a privilege level other than 0 yields the general-protection fault result (bit 1), with no flag or error write.
- R5: When the selected pointer is invalid, the result is fail-invalid (bit 3) and flags are written with only the carry flag set; flag vector order is bit 0 carry, 1 parity, 2 auxiliary, 3 zero, 4 sign, 5 overflow.
- R6: In 64-bit mode, any set bit in the upper selector half yields fail-valid (bit 4) with the unsupported-component code; outside 64-bit mode those bits are ignored.
- R7: A field reported as unsupported yields fail-valid with the unsupported-component code (parameter ERR_UNSUPP, default 12).
- R8: A write to a read-only field yields fail-valid with the read-only code (parameter ERR_RO_WRITE, default 13) unless the read-only-write capability input is high; a read of a read-only field is not affected.
- R9: On fail-valid with a valid current pointer, flags are written with only the zero flag set and the error code is strobed; with no current pointer neither flags nor error field are written.
- R10: On success (bit 5), flags are written with all six cleared and no error is strobed.
- R11: done rises exactly one cycle after start with exactly one result bit set; without start, done, result, flag and error outputs are all zero, including after reset.
- R12: Outcomes are ranked undefined-opcode, then exit or general-protection, then fail-invalid, then upper-selector and unsupported failures, then read-only failure, then success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch one decision on the sampled inputs |
| is_write | input | 1 | 1 for a field write, 0 for a field read |
| virt_on | input | 1 | Virtualization operation enabled |
| prot_mode | input | 1 | Processor in protected mode |
| compat_mode | input | 1 | 64-bit compatibility sub-mode active |
| long_mode64 | input | 1 | Full 64-bit mode active |
| cpl | input | 2 | Current privilege level |
| guest | input | 1 | Processor running a guest |
| cur_ptr_valid | input | 1 | Current structure pointer is not the all-ones value |
| link_ptr_valid | input | 1 | Shadow link pointer is not the all-ones value |
| fld_sel_hi | input | 32 | Upper half of the field selector |
| fld_supported | input | 1 | Field decoder recognises the selector |
| fld_read_only | input | 1 | Selected field is read-only |
| exit_req | input | 1 | Bitmap checker requests a VM exit |
| ro_write_cap | input | 1 | Capability permitting writes to read-only fields |
| done | output | 1 | One-cycle completion pulse |
| result | output | 6 | One-hot: 0 UD, 1 GP, 2 exit, 3 fail-invalid, 4 fail-valid, 5 success |
| flags | output | 6 | Status flags to commit (CF, PF, AF, ZF, SF, OF from bit 0) |
| flags_we | output | 1 | Commit flags this cycle |
| err_we | output | 1 | Write err_code into the instruction-error field |
| err_code | output | ERR_W | Error code, zero when err_we is low |
| use_shadow | output | 1 | Successful access goes to the shadow structure |

## Verification
The bench goes after the ranking corners: a guest at nonzero privilege must not fault (a design checking privilege in guest mode would fault instead of redirecting), and an exit request must beat an invalid link pointer. It feeds upper selector bits with 64-bit mode off, where a design that ignores the mode gate fails an access that should succeed, and read-only writes with and without the capability, where a missing capability term fails writes it should allow. It also drives fail-valid with no current pointer, where a design that always commits the zero flag or strobes the error field would corrupt state that does not exist, and a valid current pointer with an invalid link pointer in guest mode, which catches a design checking the wrong pointer.

// File: rtl/vfa_outcome_seq.sv
module vfa_outcome_seq #(
  parameter int ERR_W        = 32,
  parameter int ERR_UNSUPP   = 12,
  parameter int ERR_RO_WRITE = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_write,
  input  logic             virt_on,
  input  logic             prot_mode,
  input  logic             compat_mode,
  input  logic             long_mode64,
  input  logic [1:0]       cpl,
  input  logic             guest,
  input  logic             cur_ptr_valid,
  input  logic             link_ptr_valid,
  input  logic [31:0]      fld_sel_hi,
  input  logic             fld_supported,
  input  logic             fld_read_only,
  input  logic             exit_req,
  input  logic             ro_write_cap,
  output logic             done,
  output logic [5:0]       result,
  output logic [5:0]       flags,
  output logic             flags_we,
  output logic             err_we,
  output logic [ERR_W-1:0] err_code,
  output logic             use_shadow
);

  localparam int RES_UD   = 0;
  localparam int RES_GP   = 1;
  localparam int RES_EXIT = 2;
  localparam int RES_FINV = 3;
  localparam int RES_FVAL = 4;
  localparam int RES_OK   = 5;
  localparam int FLG_CF   = 0;
  localparam int FLG_ZF   = 3;

  logic bad_mode, take_exit, priv_fault, sel_ptr_ok, sel_hi_bad, ro_block;

  assign bad_mode   = ~virt_on | ~prot_mode | compat_mode;
  assign take_exit  = guest & exit_req;
  assign priv_fault = ~guest & (cpl != 2'd0);
  assign sel_ptr_ok = guest ? link_ptr_valid : cur_ptr_valid;
  assign sel_hi_bad = long_mode64 & (|fld_sel_hi);
  assign ro_block   = is_write & fld_read_only & ~ro_write_cap;

  logic [5:0]       nxt_res;
  logic [ERR_W-1:0] nxt_code;

  always_comb begin
    nxt_res  = '0;
    nxt_code = '0;
    if (bad_mode)                          nxt_res[RES_UD]   = 1'b1;
    else if (take_exit)                    nxt_res[RES_EXIT] = 1'b1;
    else if (priv_fault)                   nxt_res[RES_GP]   = 1'b1;
    else if (!sel_ptr_ok)                  nxt_res[RES_FINV] = 1'b1;
    else if (sel_hi_bad || !fld_supported) begin
      nxt_res[RES_FVAL] = 1'b1;
      nxt_code          = ERR_W'(ERR_UNSUPP);
    end else if (ro_block) begin
      nxt_res[RES_FVAL] = 1'b1;
      nxt_code          = ERR_W'(ERR_RO_WRITE);
    end else                               nxt_res[RES_OK]   = 1'b1;
  end

  logic [5:0] nxt_flags;
  logic       nxt_fwe, nxt_ewe;

  always_comb begin
    nxt_flags = '0;
    nxt_fwe   = nxt_res[RES_OK] | nxt_res[RES_FINV];
    nxt_ewe   = nxt_res[RES_FVAL] & cur_ptr_valid;
    if (nxt_res[RES_FINV]) nxt_flags[FLG_CF] = 1'b1;
    if (nxt_ewe) begin
      nxt_flags[FLG_ZF] = 1'b1;
      nxt_fwe           = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      result     <= '0;
      flags      <= '0;
      flags_we   <= 1'b0;
      err_we     <= 1'b0;
      err_code   <= '0;
      use_shadow <= 1'b0;
    end else if (start) begin
      done       <= 1'b1;
      result     <= nxt_res;
      flags      <= nxt_flags;
      flags_we   <= nxt_fwe;
      err_we     <= nxt_ewe;
      err_code   <= nxt_ewe ? nxt_code : '0;
      use_shadow <= nxt_res[RES_OK] & guest;
    end else begin
      done       <= 1'b0;
      result     <= '0;
      flags      <= '0;
      flags_we   <= 1'b0;
      err_we     <= 1'b0;
      err_code   <= '0;
      use_shadow <= 1'b0;
    end
  end

endmodule

// File: rtl/vfa_outcome_seq_chk.sv
module vfa_outcome_seq_chk #(
  parameter int ERR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             virt_on,
  input logic             prot_mode,
  input logic             compat_mode,
  input logic [1:0]       cpl,
  input logic             guest,
  input logic             exit_req,
  input logic             done,
  input logic [5:0]       result,
  input logic [5:0]       flags,
  input logic             flags_we,
  input logic             err_we,
  input logic [ERR_W-1:0] err_code,
  input logic             use_shadow
);

  assert_done_follows_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (result == 6'd0 && !flags_we && !err_we && err_code == '0));

  assert_result_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(result) == 1));

  assert_bad_mode_ud_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (!virt_on || !prot_mode || compat_mode)) |=> (result[0] && !flags_we && !err_we));

  assert_guest_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && virt_on && prot_mode && !compat_mode && guest && exit_req) |=> result[2]);

  assert_priv_gp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && virt_on && prot_mode && !compat_mode && !guest && cpl != 2'd0) |=> result[1]);

  assert_fail_invalid_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result[3]) |-> (flags == 6'b000001 && flags_we && !err_we));

  assert_fail_valid_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_we |-> (result[4] && flags == 6'b001000 && flags_we));

  assert_success_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result[5]) |-> (flags == 6'd0 && flags_we && !err_we));

  assert_shadow_only_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
    use_shadow |-> result[5]);

endmodule

bind vfa_outcome_seq vfa_outcome_seq_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .virt_on(virt_on), .prot_mode(prot_mode),
  .compat_mode(compat_mode), .cpl(cpl), .guest(guest), .exit_req(exit_req),
  .done(done), .result(result), .flags(flags), .flags_we(flags_we), .err_we(err_we),
  .err_code(err_code), .use_shadow(use_shadow)
);

// File: tb/vfa_outcome_seq_tb.sv
module vfa_outcome_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int EW = 32;
  localparam int UNSUPP = 12;
  localparam int ROCODE = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, is_write = 0, virt_on = 0, prot_mode = 0, compat_mode = 0, long_mode64 = 0;
  logic [1:0] cpl = 0;
  logic guest = 0, cur_ptr_valid = 0, link_ptr_valid = 0;
  logic [31:0] fld_sel_hi = 0;
  logic fld_supported = 0, fld_read_only = 0, exit_req = 0, ro_write_cap = 0;
  logic done, flags_we, err_we, use_shadow;
  logic [5:0] result, flags;
  logic [EW-1:0] err_code;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vfa_outcome_seq #(.ERR_W(EW), .ERR_UNSUPP(UNSUPP), .ERR_RO_WRITE(ROCODE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write), .virt_on(virt_on),
    .prot_mode(prot_mode), .compat_mode(compat_mode), .long_mode64(long_mode64), .cpl(cpl),
    .guest(guest), .cur_ptr_valid(cur_ptr_valid), .link_ptr_valid(link_ptr_valid),
    .fld_sel_hi(fld_sel_hi), .fld_supported(fld_supported), .fld_read_only(fld_read_only),
    .exit_req(exit_req), .ro_write_cap(ro_write_cap), .done(done), .result(result),
    .flags(flags), .flags_we(flags_we), .err_we(err_we), .err_code(err_code),
    .use_shadow(use_shadow));

  // expected outputs for the next clock, held as one packed word
  logic [47:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [47:0] pack(logic d, logic [5:0] r, logic [5:0] f,
                                       logic fw, logic ew, logic [31:0] c, logic sh);
    return {d, r, f, fw, ew, c, sh};
  endfunction

  task automatic model(output logic [47:0] e, output string tag);
    int outcome; // 0 ud 1 gp 2 exit 3 finv 4 fval 5 ok 6 idle
    int code;
    logic ptr;
    code = 0;
    tag = "R11";
    if (!start) outcome = 6;
    else if (!virt_on || !prot_mode || compat_mode) begin outcome = 0; tag = "R1"; end
    else if (guest && exit_req) begin outcome = 2; tag = "R2"; end
    else if (!guest && cpl != 0) begin outcome = 1; tag = "R4"; end
    else begin
      ptr = guest ? link_ptr_valid : cur_ptr_valid;
      if (!ptr) begin outcome = 3; tag = "R5"; end
      else if (long_mode64 && fld_sel_hi != 0) begin outcome = 4; code = UNSUPP; tag = "R6"; end
      else if (!fld_supported) begin outcome = 4; code = UNSUPP; tag = "R7"; end
      else if (is_write && fld_read_only && !ro_write_cap) begin outcome = 4; code = ROCODE; tag = "R8"; end
      else begin outcome = 5; tag = guest ? "R3" : "R10"; end
    end
    case (outcome)
      0, 1, 2: e = pack(1, 6'(1 << outcome), 0, 0, 0, 0, 0);
      3:       e = pack(1, 6'b001000, 6'b000001, 1, 0, 0, 0);
      4:       if (cur_ptr_valid) e = pack(1, 6'b010000, 6'b001000, 1, 1, code, 0);
               else begin e = pack(1, 6'b010000, 0, 0, 0, 0, 0); tag = {tag, "/R9"}; end
      5:       e = pack(1, 6'b100000, 0, 1, 0, 0, guest);
      default: e = 48'd0;
    endcase
  endtask

  task automatic compare(string tag);
    logic [47:0] act, exp;
    act = pack(done, result, flags, flags_we, err_we, err_code, use_shadow);
    exp = exp_q.pop_front();
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, compare previous cycle's expectation first
  task automatic step(string force_tag);
    logic [47:0] e;
    string t;
    model(e, t);
    if (force_tag != "") t = {force_tag, ":", t};
    if (exp_q.size() != 0) compare(tag_q.pop_front());
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
  endtask

  task automatic good_base();
    start = 1; is_write = 0; virt_on = 1; prot_mode = 1; compat_mode = 0; long_mode64 = 1;
    cpl = 0; guest = 0; cur_ptr_valid = 1; link_ptr_valid = 1; fld_sel_hi = 0;
    fld_supported = 1; fld_read_only = 0; exit_req = 0; ro_write_cap = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    checks++;
    if (done !== 0 || result !== 0 || flags_we !== 0 || err_we !== 0) begin
      fails++;
      $display("FAIL R11 reset: actual %b/%b expected 0/0", done, result);
    end
    rst_n = 1;
    @(negedge clk);
    start = 0; step("R11 idle");
    good_base(); step("R10 plain read");
    good_base(); virt_on = 0; step("R1 virt off");
    good_base(); prot_mode = 0; step("R1 real mode");
    good_base(); compat_mode = 1; guest = 1; exit_req = 1; step("R12 UD beats exit");
    good_base(); guest = 1; exit_req = 1; link_ptr_valid = 0; step("R12 exit beats bad link");
    good_base(); guest = 1; cpl = 3; step("R3 guest cpl3 no GP");
    good_base(); guest = 1; cur_ptr_valid = 1; link_ptr_valid = 0; step("R3 link checked");
    good_base(); guest = 0; link_ptr_valid = 0; step("R3 link ignored host");
    good_base(); cpl = 1; cur_ptr_valid = 0; step("R12 GP beats finv");
    good_base(); cur_ptr_valid = 0; step("R5 host finv");
    good_base(); fld_sel_hi = 32'h1; step("R6 upper bit");
    good_base(); long_mode64 = 0; fld_sel_hi = 32'hFFFF_0000; step("R6 ignored 32b");
    good_base(); fld_supported = 0; step("R7 unsupported");
    good_base(); is_write = 1; fld_read_only = 1; step("R8 ro write");
    good_base(); is_write = 1; fld_read_only = 1; ro_write_cap = 1; step("R8 cap allows");
    good_base(); is_write = 0; fld_read_only = 1; step("R8 ro read ok");
    good_base(); is_write = 1; fld_read_only = 1; fld_supported = 0; step("R12 unsupp before ro");
    good_base(); guest = 1; cur_ptr_valid = 0; fld_supported = 0; step("R9 no current ptr");
    good_base(); guest = 1; cur_ptr_valid = 0; step("R3 shadow ok no cur");
    good_base(); step("R11 back to back");
    start = 0; step("R11 idle after");
    for (int i = 0; i < 3000; i++) begin
      start = ($urandom % 4) != 0;
      is_write = $urandom; virt_on = ($urandom % 8) != 0; prot_mode = ($urandom % 8) != 0;
      compat_mode = ($urandom % 8) == 0; long_mode64 = $urandom; cpl = ($urandom % 3 == 0) ? 2'($urandom) : 2'd0;
      guest = $urandom; cur_ptr_valid = ($urandom % 6) != 0; link_ptr_valid = ($urandom % 6) != 0;
      fld_sel_hi = ($urandom % 5 == 0) ? $urandom : 32'd0; fld_supported = ($urandom % 6) != 0;
      fld_read_only = $urandom; exit_req = ($urandom % 4) == 0; ro_write_cap = $urandom;
      step("");
    end
    start = 0;
    step("R11 tail");
    compare(tag_q.pop_front());
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule